// File: doc/BRIEF.md
# Snooping Coherence State Controller for One Cache Line

This block holds the coherence state of a single private cache line that belongs to one core on a shared snooping bus. Each cycle it takes the core's local read and write requests, the read and write events snooped from other caches, and the shared and dirty responses that those caches return. From these it chooses the line's next state. When the line cannot serve the core on its own, it asks for the bus: a fill read, a read-for-ownership, or an invalidate broadcast. While that request is in flight it stalls the core. When another cache snoops a line it holds dirty, it raises a write-back request.

The core holds its request steady for as long as the stall is high. The request is taken in the first cycle in which the stall is low. A single arbiter grant input decides when this line's bus request owns the bus, so only one write event is ever on the bus at a time. Snooped events always win over the local side, because a remote agent that already owns the bus has been serialized ahead of this core.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the line state is Invalid, and no bus request, write-back or stall is raised. The state is encoded as Invalid 2'b00, Shared 2'b01, Exclusive 2'b10, Modified 2'b11.
- R2: In Modified, a local read or write is served with no stall and no bus request, and the state stays Modified.
- R3: In Exclusive, a local read keeps the state. A local write moves the line to Modified on the next clock with no stall and no bus request.
- R4: In Shared, a local read keeps the state. A local write stalls the core and raises a bus request with op code 2'b11 (invalidate) until the grant cycle. The line is Modified from the following cycle, and the stall is still high in the grant cycle.
- R5: In Invalid, a local read stalls the core and requests op 2'b01 (fill read) until granted. It then waits for the fill-done input. The line becomes Shared if the shared response is high in the completing cycle, and Exclusive otherwise.
- R6: In Invalid, a local write stalls the core and requests op 2'b10 (read-for-ownership). After the grant and the fill-done input, the line becomes Modified.
- R7: While the dirty response is high, a fill does not complete, even when fill-done is high. The other holder must write back first.
- R8: A snooped read moves Modified and Exclusive to Shared and leaves Shared unchanged. A snooped write moves Modified, Exclusive and Shared to Invalid. When either snoop hits a Modified line, the write-back request is high in that same cycle, and at no other time. A snooped write dominates a simultaneous snooped read.
- R9: Snooped reads and writes leave an Invalid line unchanged and raise no write-back.
- R10: A snoop in the same cycle as a local request is applied first. The local request is stalled in that cycle and is then served against the new state.
- R11: If a snooped write arrives while an invalidate waits for its grant, the line drops to Invalid and the pending request becomes read-for-ownership. A grant in that same cycle is ignored.
- R12: Bus op reads 2'b00 whenever no bus request is raised. A write-back request and a bus request are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_rd | input | 1 | Core read request, held while stalled |
| lcl_wr | input | 1 | Core write request, held while stalled |
| snp_rd | input | 1 | Snooped read from another cache |
| snp_wr | input | 1 | Snooped write from another cache |
| snp_shared | input | 1 | Another cache holds the line (fill result) |
| snp_dirty | input | 1 | Another cache holds the line dirty and is writing back |
| bus_gnt | input | 1 | Arbiter grant for this line's request |
| bus_done | input | 1 | Fill data delivered |
| line_state | output | 2 | Current coherence state |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_op | output | 2 | Requested operation code |
| wb_req | output | 1 | Write-back of the dirty line requested |
| core_stall | output | 1 | Core must hold its request |

## Verification
Two functions can land in the same cycle: a snoop coming in while the core presents a request, and a snooped write arriving in the cycle an invalidate is granted. The bench drives both on purpose. It drives a local write together with a snooped write on a Shared line, and a local write together with a snooped read on an Exclusive line. It also raises a snooped write and a grant together during an invalidate wait. The behavioural model in the bench judges the outcome every cycle: the snoop's state change must take effect, the local side must stall, and the pending operation must be re-issued correctly.

// File: rtl/mesi_line_pkg.sv
package mesi_line_pkg;

    localparam int ST_W = 2;
    localparam int OP_W = 2;

    typedef enum logic [ST_W-1:0] {
        LN_I = 2'b00,
        LN_S = 2'b01,
        LN_E = 2'b10,
        LN_M = 2'b11
    } line_st_e;

    typedef enum logic [OP_W-1:0] {
        OP_NONE = 2'b00,
        OP_RD   = 2'b01,
        OP_RFO  = 2'b10,
        OP_INV  = 2'b11
    } bus_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_REQ  = 2'b01,
        PH_FILL = 2'b10
    } phase_e;

    typedef struct packed {
        line_st_e st;
        phase_e   ph;
        bus_op_e  op;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{st: LN_I, ph: PH_IDLE, op: OP_NONE};

endpackage

// File: rtl/mesi_snoop_resolve.sv
module mesi_snoop_resolve
    import mesi_line_pkg::*;
(
    input  line_st_e st_in,
    input  logic     snp_rd,
    input  logic     snp_wr,
    output line_st_e st_out,
    output logic     wb_out,
    output logic     seen
);
    always_comb begin
        st_out = st_in;
        wb_out = 1'b0;
        seen   = snp_rd | snp_wr;
        if (snp_wr) begin
            // a remote writer takes ownership: every valid copy dies
            st_out = LN_I;
            wb_out = (st_in == LN_M);
        end else if (snp_rd) begin
            if (st_in == LN_M || st_in == LN_E) st_out = LN_S;
            wb_out = (st_in == LN_M);
        end
    end
endmodule

// File: rtl/mesi_local_decode.sv
module mesi_local_decode
    import mesi_line_pkg::*;
(
    input  line_st_e st_in,
    input  logic     lcl_rd,
    input  logic     lcl_wr,
    output logic     hit,
    output line_st_e st_hit,
    output bus_op_e  miss_op
);
    always_comb begin
        hit     = 1'b0;
        st_hit  = st_in;
        miss_op = OP_NONE;
        unique case (st_in)
            LN_M: hit = lcl_rd | lcl_wr;
            LN_E: begin
                hit = lcl_rd | lcl_wr;
                if (lcl_wr) st_hit = LN_M;
            end
            LN_S: begin
                if (lcl_wr)      miss_op = OP_INV;
                else if (lcl_rd) hit = 1'b1;
            end
            LN_I: begin
                if (lcl_wr)      miss_op = OP_RFO;
                else if (lcl_rd) miss_op = OP_RD;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mesi_fill_resolve.sv
module mesi_fill_resolve
    import mesi_line_pkg::*;
(
    input  bus_op_e  op_in,
    input  logic     shared_in,
    output line_st_e st_fill
);
    always_comb begin
        if (op_in == OP_RD) st_fill = shared_in ? LN_S : LN_E;
        else                st_fill = LN_M;
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_line_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lcl_rd,
    input  logic            lcl_wr,
    input  logic            snp_rd,
    input  logic            snp_wr,
    input  logic            snp_shared,
    input  logic            snp_dirty,
    input  logic            bus_gnt,
    input  logic            bus_done,
    output logic [ST_W-1:0] line_state,
    output logic            bus_req,
    output logic [OP_W-1:0] bus_op,
    output logic            wb_req,
    output logic            core_stall
);
    ctl_t ctl_d, ctl_q;

    line_st_e snp_st, hit_st, fill_st;
    logic     snp_wb, snp_seen, lcl_hit;
    bus_op_e  lcl_miss_op;

    mesi_snoop_resolve i_snoop (
        .st_in (ctl_q.st),
        .snp_rd(snp_rd),
        .snp_wr(snp_wr),
        .st_out(snp_st),
        .wb_out(snp_wb),
        .seen  (snp_seen)
    );

    mesi_local_decode i_local (
        .st_in  (ctl_q.st),
        .lcl_rd (lcl_rd),
        .lcl_wr (lcl_wr),
        .hit    (lcl_hit),
        .st_hit (hit_st),
        .miss_op(lcl_miss_op)
    );

    mesi_fill_resolve i_fill (
        .op_in    (ctl_q.op),
        .shared_in(snp_shared),
        .st_fill  (fill_st)
    );

    logic    stall_c, req_c;
    bus_op_e op_c;

    always_comb begin
        ctl_d   = ctl_q;
        stall_c = 1'b0;
        req_c   = 1'b0;
        op_c    = OP_NONE;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (snp_seen) begin
                    ctl_d.st = snp_st;
                    stall_c  = lcl_rd | lcl_wr;
                end else if (lcl_hit) begin
                    ctl_d.st = hit_st;
                end else if (lcl_miss_op != OP_NONE) begin
                    ctl_d.ph = PH_REQ;
                    ctl_d.op = lcl_miss_op;
                    stall_c  = 1'b1;
                end
            end
            PH_REQ: begin
                stall_c = 1'b1;
                req_c   = 1'b1;
                op_c    = ctl_q.op;
                if (snp_wr && ctl_q.op == OP_INV) begin
                    ctl_d.st = LN_I;
                    ctl_d.op = OP_RFO;
                end else if (snp_seen) begin
                    ctl_d.st = snp_st;
                end else if (bus_gnt) begin
                    if (ctl_q.op == OP_INV) begin
                        ctl_d.st = LN_M;
                        ctl_d.ph = PH_IDLE;
                        ctl_d.op = OP_NONE;
                    end else begin
                        ctl_d.ph = PH_FILL;
                    end
                end
            end
            PH_FILL: begin
                stall_c = 1'b1;
                if (bus_done && !snp_dirty) begin
                    ctl_d.st = fill_st;
                    ctl_d.ph = PH_IDLE;
                    ctl_d.op = OP_NONE;
                end
            end
            default: ctl_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign line_state = ctl_q.st;
    assign bus_req    = req_c;
    assign bus_op     = op_c;
    assign wb_req     = snp_wb;
    assign core_stall = stall_c;

    // R8: write-back only ever leaves a dirty line
    p_wb_from_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (line_state == LN_M));

    // R12: write-back and own bus request never coincide
    p_wb_excl_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_req && bus_req));

    // R4: invalidate is only requested for a Shared copy, under stall
    p_inv_from_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_op == OP_INV) |-> (line_state == LN_S && core_stall));

    // R5/R6: fills are only requested for an Invalid line
    p_fill_from_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_op == OP_RD || bus_op == OP_RFO)) |-> (line_state == LN_I));

    // R7: no fill completion while a dirty holder is writing back
    p_dirty_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LN_I && snp_dirty) |=> (line_state == LN_I));

    // R9: snoops never revive an Invalid line
    p_snoop_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LN_I && (snp_rd || snp_wr)) |=> (line_state == LN_I));

    // R3: Modified is entered only after a local write
    p_m_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LN_M && $past(line_state) != LN_M) |-> $past(lcl_wr));

endmodule

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lcl_rd = 0, lcl_wr = 0, snp_rd = 0, snp_wr = 0;
    logic       snp_shared = 0, snp_dirty = 0, bus_gnt = 0, bus_done = 0;
    logic [1:0] line_state, bus_op;
    logic       bus_req, wb_req, core_stall;

    mesi_line_ctrl i_mesi_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .lcl_rd(lcl_rd), .lcl_wr(lcl_wr),
        .snp_rd(snp_rd), .snp_wr(snp_wr),
        .snp_shared(snp_shared), .snp_dirty(snp_dirty),
        .bus_gnt(bus_gnt), .bus_done(bus_done),
        .line_state(line_state), .bus_req(bus_req), .bus_op(bus_op),
        .wb_req(wb_req), .core_stall(core_stall)
    );

    always #5 clk = ~clk;

    int    n_chk = 0, n_bad = 0, cyc_cnt = 0;
    string tag = "R1";
    bit    done_run = 0;

    // behavioural reference: 0=I 1=S 2=E 3=M; wait: 0 none, 1 arbitration, 2 data
    int m_line = 0, m_wait = 0, m_kind = 0;

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int e_stall, e_req, e_op, e_wb, nxt_line, nxt_wait, nxt_kind;
        bit any_snp;
        if (rst_n && !done_run) begin
            any_snp  = snp_rd || snp_wr;
            e_wb     = (any_snp && m_line == 3) ? 1 : 0;
            e_req    = (m_wait == 1) ? 1 : 0;
            e_op     = (m_wait == 1) ? m_kind : 0;
            e_stall  = 0;
            nxt_line = m_line; nxt_wait = m_wait; nxt_kind = m_kind;
            if (any_snp && m_wait != 2) begin
                if (snp_wr) nxt_line = 0;
                else if (m_line >= 2) nxt_line = 1;
            end
            if (m_wait == 0) begin
                if (any_snp) e_stall = (lcl_rd || lcl_wr) ? 1 : 0;
                else if (lcl_wr && m_line == 2) nxt_line = 3;
                else if (lcl_wr && m_line <= 1) begin
                    e_stall = 1; nxt_wait = 1; nxt_kind = (m_line == 1) ? 3 : 2;
                end else if (lcl_rd && m_line == 0) begin
                    e_stall = 1; nxt_wait = 1; nxt_kind = 1;
                end
            end else if (m_wait == 1) begin
                e_stall = 1;
                if (snp_wr && m_kind == 3) nxt_kind = 2;
                else if (!any_snp && bus_gnt) begin
                    if (m_kind == 3) begin nxt_line = 3; nxt_wait = 0; nxt_kind = 0; end
                    else nxt_wait = 2;
                end
            end else begin
                e_stall = 1;
                if (bus_done && !snp_dirty) begin
                    nxt_line = (m_kind == 1) ? (snp_shared ? 1 : 2) : 3;
                    nxt_wait = 0; nxt_kind = 0;
                end
            end
            chk("line_state", line_state, m_line);
            chk("core_stall", core_stall, e_stall);
            chk("bus_req", bus_req, e_req);
            chk("bus_op", bus_op, e_op);
            chk("wb_req", wb_req, e_wb);
            m_line = nxt_line; m_wait = nxt_wait; m_kind = nxt_kind;
        end
    end

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic clear_in();
        lcl_rd = 0; lcl_wr = 0; snp_rd = 0; snp_wr = 0;
        snp_shared = 0; snp_dirty = 0; bus_gnt = 0; bus_done = 0;
    endtask

    // fill sequence: hold request, grant, then done
    task automatic grant_and_fill(int wait_gnt, bit shared);
        step(wait_gnt);
        bus_gnt = 1; step(1); bus_gnt = 0;
        step(1);
        bus_done = 1; snp_shared = shared; step(1);
        bus_done = 0; snp_shared = 0;
    endtask

    task automatic finish_run();
        done_run = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000 && !done_run) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        tag = "R1"; step(3);

        // I read, no sharer -> E
        tag = "R5"; lcl_rd = 1; grant_and_fill(2, 0); step(1); lcl_rd = 0; step(1);
        tag = "R3"; lcl_rd = 1; step(1); lcl_rd = 0; lcl_wr = 1; step(1); lcl_wr = 0; step(1);
        tag = "R2"; lcl_rd = 1; step(2); lcl_rd = 0; lcl_wr = 1; step(2); lcl_wr = 0; step(1);
        tag = "R8"; snp_rd = 1; step(1); snp_rd = 0; step(1);
        tag = "R4"; lcl_rd = 1; step(1); lcl_rd = 0;
        lcl_wr = 1; step(2); bus_gnt = 1; step(1); bus_gnt = 0; step(1); lcl_wr = 0; step(1);
        tag = "R8"; snp_wr = 1; snp_rd = 1; step(1); clear_in(); step(1);
        tag = "R6"; lcl_wr = 1; step(1); bus_gnt = 1; step(1); bus_gnt = 0;
        tag = "R7"; bus_done = 1; snp_dirty = 1; step(2); snp_dirty = 0; step(1); bus_done = 0;
        step(1); lcl_wr = 0; step(1);
        tag = "R8"; snp_rd = 1; step(1); snp_rd = 0; step(1);
        tag = "R11"; lcl_wr = 1; step(2); snp_wr = 1; bus_gnt = 1; step(1); snp_wr = 0; bus_gnt = 0;
        step(1); grant_and_fill(0, 1); step(1); lcl_wr = 0; step(1);
        tag = "R8"; snp_wr = 1; step(1); snp_wr = 0; step(1);
        tag = "R9"; snp_rd = 1; step(1); snp_rd = 0; snp_wr = 1; step(1); snp_wr = 0; step(1);
        tag = "R5"; lcl_rd = 1; grant_and_fill(1, 1); step(1); lcl_rd = 0; step(1);
        tag = "R10"; lcl_wr = 1; snp_wr = 1; step(1); snp_wr = 0; step(1);
        grant_and_fill(0, 0); step(1); lcl_wr = 0; step(1);
        snp_wr = 1; step(1); snp_wr = 0;
        lcl_rd = 1; grant_and_fill(0, 0); step(1); lcl_rd = 0; step(1);
        lcl_wr = 1; snp_rd = 1; step(1); snp_rd = 0; step(2);
        bus_gnt = 1; step(1); bus_gnt = 0; step(1); lcl_wr = 0; step(1);
        tag = "R8"; snp_wr = 1; step(1); snp_wr = 0;
        lcl_rd = 1; grant_and_fill(0, 0); step(1); lcl_rd = 0; snp_wr = 1; step(1); snp_wr = 0; step(1);
        tag = "R12"; bus_gnt = 1; bus_done = 1; step(3); clear_in(); step(2);
        finish_run();
    end

endmodule